// File: doc/BRIEF.md
# Adjacent Instruction Pair Fusion Detector

This block sits in a wide decode stage and looks at a group of up to six 32-bit RV64 instruction words at once, each with its own valid bit. It tests every pair of neighbouring slots against a fixed set of two-instruction idioms: shift pairs that zero- or sign-extend, shift-then-add, extract-byte, and add-one-if-odd. When a pair matches, the lower slot is flagged as the start of a fused operation. It also carries a fused operation code, the merged source registers and the shared destination. The upper slot is flagged to be dropped.

Pairs are claimed greedily from slot 0 upward. A slot already taken as the second half of a fusion cannot also begin another one. The matching is combinational. A parameter selects an output register stage, which is on by default.

Top module: `fuse_pair_detect`

## Requirements
- R1: With the default registered output, the results for a group appear on the outputs one clock edge after that group is applied. While `rst_n` is low, every output is zero.
- R2: The following shift pairs fuse. `slli d,s,32` then `srli d,d,32` gives code 1. `slli d,s,48` then `srli d,d,48` gives code 2. `slliw d,s,16` then `srliw d,d,16` gives code 3. `slliw d,s,16` then `sraiw d,d,16` gives code 4. Any other shift amount does not fuse.
- R3: A pair fuses only if all of the following hold. The second instruction's rd and rs1 both equal the first instruction's rd. That rd is not x0. For the add forms, the second instruction's rs2 differs from that rd.
- R4: `slli d,s,N` then `add d,d,t` fuses with code 4+N for N in 1..4. `srli d,s,N` then `add d,d,t` fuses with code N-20 for N in 29..32. Other shift amounts do not fuse.
- R5: `srli d,s,8` then `andi d,d,255` fuses with code 13. `andi d,s,1` then `add d,d,t` fuses with code 14. `andi d,s,1` then `addw d,d,t` fuses with code 15. Code 0 means no fusion.
- R6: Pairs are claimed greedily from the lowest slot. A slot that is dropped as the second half of one fusion never starts another. For every fused slot i, `out_drop[i+1]` is 1.
- R7: A pair fuses only when both of its slots are valid. The last slot never starts a fusion.
- R8: A fused slot outputs the first instruction's rs1 as source 1 and the shared rd as its destination. Source 2 is the add's rs2 for the add forms and 0 for the others. Every slot that is not fused outputs zero in all of these fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 6 | Valid bit per slot |
| in_instr | input | 192 | Instruction words, slot 0 in bits 31:0 |
| out_fuse | output | 6 | Slot starts a fused pair |
| out_drop | output | 6 | Slot is absorbed by the slot below |
| out_op | output | 24 | 4-bit fused code per slot |
| out_src1 | output | 30 | 5-bit source 1 per slot |
| out_src2 | output | 30 | 5-bit source 2 per slot |
| out_dst | output | 30 | 5-bit destination per slot |

## Verification
Two functions can collide in the same cycle: one slot can be the second half of a claimed pair and also the first half of a second matching pair. The bench sets this up in a group where slots 0-1 form a zero-extend pair and slots 1-2 also form a valid shift-and-add pair. It then checks that only slot 0 is fused, that slot 1 is dropped, and that slot 1 reports code 0. A fourth pair later in the same group is checked to confirm that fusion resumes after the conflict.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   localparam int unsigned ILEN    = 32;
   localparam int unsigned REGW    = 5;
   localparam int unsigned OPW     = 4;

   typedef enum logic [OPW-1:0] {
      FOP_NONE    = 4'd0,
      FOP_ZEXTW   = 4'd1,
      FOP_ZEXTH   = 4'd2,
      FOP_ZEXTHW  = 4'd3,
      FOP_SEXTHW  = 4'd4,
      FOP_SHADD1  = 4'd5,
      FOP_SHADD2  = 4'd6,
      FOP_SHADD3  = 4'd7,
      FOP_SHADD4  = 4'd8,
      FOP_SRADD29 = 4'd9,
      FOP_SRADD30 = 4'd10,
      FOP_SRADD31 = 4'd11,
      FOP_SRADD32 = 4'd12,
      FOP_BYTE1   = 4'd13,
      FOP_ODDADD  = 4'd14,
      FOP_ODDADDW = 4'd15
   } fuse_op_e;

   localparam logic [6:0] OPC_IMM   = 7'h13;
   localparam logic [6:0] OPC_IMMW  = 7'h1B;
   localparam logic [6:0] OPC_REG   = 7'h33;
   localparam logic [6:0] OPC_REGW  = 7'h3B;

   typedef struct packed {
      logic [REGW-1:0] src1;
      logic [REGW-1:0] src2;
      logic [REGW-1:0] dst;
   } fuse_regs_t;

   function automatic logic [REGW-1:0] fld_rd(input logic [ILEN-1:0] w);
      return w[11:7];
   endfunction

   function automatic logic [REGW-1:0] fld_rs1(input logic [ILEN-1:0] w);
      return w[19:15];
   endfunction

   function automatic logic [REGW-1:0] fld_rs2(input logic [ILEN-1:0] w);
      return w[24:20];
   endfunction
endpackage

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
   import fuse_pkg::*;
(
   input  logic [ILEN-1:0] first_w,
   input  logic [ILEN-1:0] second_w,
   input  logic            both_valid,
   output logic            hit,
   output fuse_op_e        op,
   output fuse_regs_t      regs
);
   logic [REGW-1:0] a_rd, a_rs1, b_rd, b_rs1, b_rs2;
   logic [2:0]      a_f3, b_f3;
   logic [5:0]      a_sh6, b_sh6;
   logic [4:0]      a_sh5, b_sh5;
   logic [11:0]     a_imm, b_imm;
   logic a_slli, a_srli, a_andi, a_slliw;
   logic b_srli, b_andi, b_srliw, b_sraiw, b_add, b_addw;
   logic link, add_ok, addw_ok, add_form;
   fuse_op_e cand;

   always_comb begin
      a_rd  = fld_rd(first_w);
      a_rs1 = fld_rs1(first_w);
      b_rd  = fld_rd(second_w);
      b_rs1 = fld_rs1(second_w);
      b_rs2 = fld_rs2(second_w);
      a_f3  = first_w[14:12];
      b_f3  = second_w[14:12];
      a_sh6 = first_w[25:20];
      b_sh6 = second_w[25:20];
      a_sh5 = first_w[24:20];
      b_sh5 = second_w[24:20];
      a_imm = first_w[31:20];
      b_imm = second_w[31:20];

      a_slli  = (first_w[6:0] == OPC_IMM)  && (a_f3 == 3'b001) && (first_w[31:26] == 6'd0);
      a_srli  = (first_w[6:0] == OPC_IMM)  && (a_f3 == 3'b101) && (first_w[31:26] == 6'd0);
      a_andi  = (first_w[6:0] == OPC_IMM)  && (a_f3 == 3'b111);
      a_slliw = (first_w[6:0] == OPC_IMMW) && (a_f3 == 3'b001) && (first_w[31:25] == 7'd0);

      b_srli  = (second_w[6:0] == OPC_IMM)  && (b_f3 == 3'b101) && (second_w[31:26] == 6'd0);
      b_andi  = (second_w[6:0] == OPC_IMM)  && (b_f3 == 3'b111);
      b_srliw = (second_w[6:0] == OPC_IMMW) && (b_f3 == 3'b101) && (second_w[31:25] == 7'd0);
      b_sraiw = (second_w[6:0] == OPC_IMMW) && (b_f3 == 3'b101) && (second_w[31:25] == 7'b0100000);
      b_add   = (second_w[6:0] == OPC_REG)  && (b_f3 == 3'b000) && (second_w[31:25] == 7'd0);
      b_addw  = (second_w[6:0] == OPC_REGW) && (b_f3 == 3'b000) && (second_w[31:25] == 7'd0);

      link    = (b_rd == a_rd) && (b_rs1 == a_rd) && (a_rd != '0);
      add_ok  = b_add  && (b_rs2 != a_rd);
      addw_ok = b_addw && (b_rs2 != a_rd);

      cand     = FOP_NONE;
      add_form = 1'b0;
      if (a_slli && b_srli && a_sh6 == 6'd32 && b_sh6 == 6'd32)
         cand = FOP_ZEXTW;
      else if (a_slli && b_srli && a_sh6 == 6'd48 && b_sh6 == 6'd48)
         cand = FOP_ZEXTH;
      else if (a_slliw && b_srliw && a_sh5 == 5'd16 && b_sh5 == 5'd16)
         cand = FOP_ZEXTHW;
      else if (a_slliw && b_sraiw && a_sh5 == 5'd16 && b_sh5 == 5'd16)
         cand = FOP_SEXTHW;
      else if (a_slli && add_ok && a_sh6 >= 6'd1 && a_sh6 <= 6'd4) begin
         cand     = fuse_op_e'(4'(a_sh6) + 4'd4);
         add_form = 1'b1;
      end else if (a_srli && add_ok && a_sh6 >= 6'd29 && a_sh6 <= 6'd32) begin
         cand     = fuse_op_e'(4'(a_sh6 - 6'd20));
         add_form = 1'b1;
      end else if (a_srli && b_andi && a_sh6 == 6'd8 && b_imm == 12'd255)
         cand = FOP_BYTE1;
      else if (a_andi && a_imm == 12'd1 && add_ok) begin
         cand     = FOP_ODDADD;
         add_form = 1'b1;
      end else if (a_andi && a_imm == 12'd1 && addw_ok) begin
         cand     = FOP_ODDADDW;
         add_form = 1'b1;
      end

      hit       = both_valid && link && (cand != FOP_NONE);
      op        = hit ? cand : FOP_NONE;
      regs.src1 = hit ? a_rs1 : '0;
      regs.src2 = (hit && add_form) ? b_rs2 : '0;
      regs.dst  = hit ? a_rd : '0;
   end
endmodule

// File: rtl/fuse_claim_chain.sv
module fuse_claim_chain #(
   parameter int unsigned LANES = 6
) (
   input  logic [LANES-2:0] pair_hit,
   output logic [LANES-1:0] start,
   output logic [LANES-1:0] drop
);
   initial begin
      if (LANES < 2) $error("fuse_claim_chain: LANES must be at least 2");
   end

   always_comb begin
      logic taken;
      taken = 1'b0;
      start = '0;
      for (int i = 0; i < LANES - 1; i++) begin
         start[i] = pair_hit[i] && !taken;
         taken    = start[i];
      end
      drop = {start[LANES-2:0], 1'b0};
   end
endmodule

// File: rtl/fuse_out_stage.sv
module fuse_out_stage #(
   parameter int unsigned WIDTH      = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1) $error("fuse_out_stage: WIDTH must be positive");
   end

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
   import fuse_pkg::*;
#(
   parameter int unsigned LANES      = 6,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LANES-1:0]      in_valid,
   input  logic [LANES*ILEN-1:0] in_instr,
   output logic [LANES-1:0]      out_fuse,
   output logic [LANES-1:0]      out_drop,
   output logic [LANES*OPW-1:0]  out_op,
   output logic [LANES*REGW-1:0] out_src1,
   output logic [LANES*REGW-1:0] out_src2,
   output logic [LANES*REGW-1:0] out_dst
);
   localparam int unsigned PAIRS  = LANES - 1;
   localparam int unsigned LANE_W = 2 + OPW + 3 * REGW;
   localparam int unsigned BUS_W  = LANES * LANE_W;

   initial begin
      if (LANES < 2)   $error("fuse_pair_detect: LANES must be at least 2");
      if (ILEN != 32)  $error("fuse_pair_detect: instruction width must be 32");
   end

   logic [PAIRS-1:0] pair_hit;
   fuse_op_e         pair_op   [PAIRS];
   fuse_regs_t       pair_regs [PAIRS];
   logic [LANES-1:0] start, drop;
   logic [BUS_W-1:0] bus_d, bus_q;

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         fuse_pair_match u_match (
            .first_w    (in_instr[p*ILEN +: ILEN]),
            .second_w   (in_instr[(p+1)*ILEN +: ILEN]),
            .both_valid (in_valid[p] && in_valid[p+1]),
            .hit        (pair_hit[p]),
            .op         (pair_op[p]),
            .regs       (pair_regs[p])
         );
      end
   endgenerate

   fuse_claim_chain #(.LANES(LANES)) u_chain (
      .pair_hit (pair_hit),
      .start    (start),
      .drop     (drop)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (l < PAIRS) begin : g_src
            assign bus_d[l*LANE_W +: LANE_W] = start[l]
               ? {1'b1, drop[l], OPW'(pair_op[l]), pair_regs[l]}
               : {1'b0, drop[l], {(OPW + 3*REGW){1'b0}}};
         end else begin : g_tail
            assign bus_d[l*LANE_W +: LANE_W] = {1'b0, drop[l], {(OPW + 3*REGW){1'b0}}};
         end
      end
   endgenerate

   fuse_out_stage #(.WIDTH(BUS_W), .REGISTERED(REGISTERED)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_d),
      .q     (bus_q)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_unpack
         localparam int unsigned B = l * LANE_W;
         assign out_fuse[l]             = bus_q[B + LANE_W - 1];
         assign out_drop[l]             = bus_q[B + LANE_W - 2];
         assign out_op[l*OPW +: OPW]    = bus_q[B + 3*REGW +: OPW];
         assign out_src1[l*REGW +: REGW] = bus_q[B + 2*REGW +: REGW];
         assign out_src2[l*REGW +: REGW] = bus_q[B + REGW +: REGW];
         assign out_dst[l*REGW +: REGW]  = bus_q[B +: REGW];
      end
   endgenerate
endmodule

// File: rtl/fuse_pair_detect_chk.sv
module fuse_pair_detect_chk #(
   parameter int unsigned LANES      = 6,
   parameter bit          REGISTERED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LANES-1:0]   in_valid,
   input logic [LANES-1:0]   out_fuse,
   input logic [LANES-1:0]   out_drop,
   input logic [LANES*4-1:0] out_op,
   input logic [LANES*5-1:0] out_dst
);
   assert_claim_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fuse & out_drop) == '0);

   assert_drop_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_drop == {out_fuse[LANES-2:0], 1'b0});

   assert_last_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_fuse[LANES-1]);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assert_code_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_fuse[l] == (out_op[l*4 +: 4] != 4'd0));
         assert_dst_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_fuse[l] |-> (out_dst[l*5 +: 5] != 5'd0));
      end
      for (genvar l = 0; l < LANES - 1; l++) begin : g_pairv
         if (REGISTERED) begin : g_lat
            assert_valid_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
               out_fuse[l] |-> ($past(in_valid[l]) && $past(in_valid[l+1])));
         end else begin : g_comb
            assert_valid_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
               out_fuse[l] |-> (in_valid[l] && in_valid[l+1]));
         end
      end
   endgenerate
endmodule

bind fuse_pair_detect fuse_pair_detect_chk #(.LANES(LANES), .REGISTERED(REGISTERED)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .out_fuse (out_fuse),
   .out_drop (out_drop),
   .out_op   (out_op),
   .out_dst  (out_dst)
);

// File: tb/fuse_pair_detect_tb.sv
module fuse_pair_detect_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int L   = 6;
   localparam int VW  = 6 + 192 + 24;
   localparam int NV  = 10;

   function automatic logic [31:0] enc_i(input logic [6:0] opc, input logic [2:0] f3,
                                          input int rd, input int rs, input logic [11:0] imm);
      return {imm, 5'(rs), f3, 5'(rd), opc};
   endfunction
   function automatic logic [31:0] enc_r(input logic [6:0] opc, input int rd, input int rs, input int rt);
      return {7'd0, 5'(rt), 5'(rs), 3'b000, 5'(rd), opc};
   endfunction
   function automatic logic [31:0] slli(input int rd, input int rs, input int sh);
      return enc_i(7'h13, 3'b001, rd, rs, {6'd0, 6'(sh)});
   endfunction
   function automatic logic [31:0] srli(input int rd, input int rs, input int sh);
      return enc_i(7'h13, 3'b101, rd, rs, {6'd0, 6'(sh)});
   endfunction
   function automatic logic [31:0] andi(input int rd, input int rs, input int imm);
      return enc_i(7'h13, 3'b111, rd, rs, 12'(imm));
   endfunction
   function automatic logic [31:0] slliw(input int rd, input int rs, input int sh);
      return enc_i(7'h1B, 3'b001, rd, rs, {7'd0, 5'(sh)});
   endfunction
   function automatic logic [31:0] srliw(input int rd, input int rs, input int sh);
      return enc_i(7'h1B, 3'b101, rd, rs, {7'd0, 5'(sh)});
   endfunction
   function automatic logic [31:0] sraiw(input int rd, input int rs, input int sh);
      return enc_i(7'h1B, 3'b101, rd, rs, {7'b0100000, 5'(sh)});
   endfunction
   function automatic logic [31:0] add(input int rd, input int rs, input int rt);
      return enc_r(7'h33, rd, rs, rt);
   endfunction
   function automatic logic [31:0] addw(input int rd, input int rs, input int rt);
      return enc_r(7'h3B, rd, rs, rt);
   endfunction
   localparam logic [31:0] NOP = 32'h0000_0013;

   function automatic logic [VW-1:0] vec(input logic [5:0] v,
      input logic [31:0] i0, input logic [31:0] i1, input logic [31:0] i2,
      input logic [31:0] i3, input logic [31:0] i4, input logic [31:0] i5,
      input int o0, input int o1, input int o2, input int o3, input int o4, input int o5);
      return {v, i5, i4, i3, i2, i1, i0, 4'(o5), 4'(o4), 4'(o3), 4'(o2), 4'(o1), 4'(o0)};
   endfunction

   localparam logic [VW-1:0] VECS [NV] = '{
      // R2 R5: zero-extend word, 16-bit sign-extend, second byte
      vec(6'h3F, slli(5,6,32), srli(5,5,32), slliw(7,8,16), sraiw(7,7,16), srli(9,10,8), andi(9,9,255), 1,0,4,0,13,0),
      // R2 R5: zero-extend halfword, word 16-bit zero-extend, odd add
      vec(6'h3F, slli(5,6,48), srli(5,5,48), slliw(1,2,16), srliw(1,1,16), andi(3,4,1), add(3,3,11), 2,0,3,0,14,0),
      // R4 R5: shift-add 1 and 3, odd add word form
      vec(6'h3F, slli(5,6,1), add(5,5,7), slli(8,9,3), add(8,8,1), andi(3,4,1), addw(3,3,2), 5,0,7,0,15,0),
      // R4: shift-add 2 and 4, shift-right-add 29
      vec(6'h3F, slli(5,6,2), add(5,5,7), slli(8,9,4), add(8,8,1), srli(3,4,29), add(3,3,2), 6,0,8,0,9,0),
      // R4: shift-right-add 30, 31, 32
      vec(6'h3F, srli(5,6,30), add(5,5,7), srli(8,9,31), add(8,8,1), srli(3,4,32), add(3,3,2), 10,0,11,0,12,0),
      // R6: slot 1 is claimed by pair 0, so pair 1 is not fused
      vec(6'h3F, slli(5,6,32), srli(5,5,32), add(5,5,7), andi(1,2,1), add(1,1,3), NOP, 1,0,0,14,0,0),
      // R3: rd mismatch, rd x0, rs2 equal to rd
      vec(6'h3F, slli(5,6,32), srli(6,5,32), slli(0,6,1), add(0,0,7), slli(5,6,1), add(5,5,5), 0,0,0,0,0,0),
      // R7: slot 1 invalid breaks pair 0
      vec(6'h3D, slli(5,6,32), srli(5,5,32), slliw(7,8,16), sraiw(7,7,16), srli(9,10,8), andi(9,9,255), 0,0,4,0,13,0),
      // R2 R4: near-miss shift amounts
      vec(6'h3F, slli(5,6,32), srli(5,5,31), slli(5,6,5), add(5,5,7), slliw(1,2,16), srliw(1,1,15), 0,0,0,0,0,0),
      // R7: odd alignment, last slot alone
      vec(6'h3F, NOP, slli(5,6,32), srli(5,5,32), slli(8,9,1), add(8,8,1), slli(3,4,1), 0,1,0,5,0,0)
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [L-1:0]     in_valid = '0;
   logic [L*32-1:0]  in_instr = '0;
   logic [L-1:0]     out_fuse, out_drop;
   logic [L*4-1:0]   out_op;
   logic [L*5-1:0]   out_src1, out_src2, out_dst;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fuse_pair_detect dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .out_fuse(out_fuse), .out_drop(out_drop), .out_op(out_op),
      .out_src1(out_src1), .out_src2(out_src2), .out_dst(out_dst)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] v, input logic [191:0] w);
      @(negedge clk);
      in_valid = v;
      in_instr = w;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] eop;
      logic [5:0]  efuse;
      // R1: reset state with a fusible group present
      in_valid = 6'h3F;
      in_instr = VECS[0][215:24];
      repeat (3) @(negedge clk);
      check("R1", "reset fuse", 32'(out_fuse), 32'd0);
      check("R1", "reset op", 32'(out_op), 32'd0);
      check("R1", "reset dst", 32'(out_dst), 32'd0);
      rst_n = 1'b1;
      in_valid = '0;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         apply(VECS[k][221:216], VECS[k][215:24]);
         eop = VECS[k][23:0];
         for (int i = 0; i < L; i++) efuse[i] = (eop[i*4 +: 4] != 4'd0);
         check("R2 R4 R5", $sformatf("vec%0d op", k), 32'(out_op), 32'(eop));
         check("R3 R7", $sformatf("vec%0d fuse", k), 32'(out_fuse), 32'(efuse));
         check("R6", $sformatf("vec%0d drop", k), 32'(out_drop), 32'({efuse[4:0], 1'b0}));
      end

      // R8: operands of shift-add and of zero-extend word
      apply(6'h3F, {NOP, NOP, srli(9,10,32), slli(9,10,32)+32'd0, add(5,5,7), slli(5,6,1)});
      check("R8", "lane0 src1", 32'(out_src1[4:0]), 32'd6);
      check("R8", "lane0 src2", 32'(out_src2[4:0]), 32'd7);
      check("R8", "lane0 dst", 32'(out_dst[4:0]), 32'd5);
      check("R8", "lane1 zero", 32'({out_src1[9:5], out_src2[9:5], out_dst[9:5]}), 32'd0);
      apply(6'h3F, {NOP, NOP, NOP, NOP, srli(9,9,32), slli(9,10,32)});
      check("R8", "zextw src1", 32'(out_src1[4:0]), 32'd10);
      check("R8", "zextw src2", 32'(out_src2[4:0]), 32'd0);
      check("R8", "zextw dst", 32'(out_dst[4:0]), 32'd9);

      // R1: output changes only after the clock edge
      @(negedge clk);
      in_valid = 6'h3F;
      in_instr = VECS[2][215:24];
      #1;
      check("R1", "before edge", 32'(out_op), 32'h000_001);
      @(negedge clk);
      check("R1", "after edge", 32'(out_op), 32'(VECS[2][23:0]));

      // R1: asynchronous reset clears outputs
      #1 rst_n = 1'b0;
      #1;
      check("R1", "async clear", 32'(out_fuse), 32'd0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule